// File: doc/BRIEF.md
# Triple Reload Timer with Wide Free-Running Counter

This peripheral sits on a simple word-addressed register bus. It holds three self-reloading down-counters and one 40-bit up-counter. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Each channel has four word registers: a reload value, a live count, a control word, and a clear port. Writing any value to the clear port removes that channel's pending interrupt. When a channel passes below zero, it raises its own interrupt line.

The three channels count on a main tick enable or on a slower alternative tick enable; each channel's control word picks one. The wide counter counts on a separate fast tick enable and never raises an interrupt. Software reads its low 32 bits first. That read captures the upper 8 bits, so the following read of the high word gives a consistent 40-bit value. The high word also carries the counter's enable.

Each down-channel is a two-state machine: `CH_OFF` moves to `CH_RUN` when a control write sets the enable bit, and `CH_RUN` returns to `CH_OFF` when a control write clears it. The wide counter has its own two-state machine: `FR_OFF` moves to `FR_RUN` when a high-word write sets the enable bit, and back again when a high-word write clears it.

Top module: `reload_timer_bank`

## Requirements
- R1: After reset, every count, reload value and control word reads as zero, the wide counter is off and reads zero, and all three interrupt lines are low.
- R2: Channel register blocks start at 0x00, 0x20 and 0x80. Within a block, +0x0 is reload, +0x4 is count, +0x8 is control and +0xC is clear. The wide counter's low word is at 0x60 and its high word at 0x64. Any other address, including an address not a multiple of 4, reads as zero and writes to it have no effect. Read data appears on `bus_rdata` in the cycle after the `bus_rd` strobe and holds until the next read.
- R3: In the control word, bit 7 is enable, bit 6 is periodic mode and bit 3 is clock select. A control read returns those three bits in place and zero in every other bit.
- R4: A reload write while the channel is disabled also copies the value into the count, and enabling starts counting from that count. A reload write while the channel is enabled changes only the reload register.
- R5: In periodic mode, a selected tick at count zero loads the reload value and sets the channel's interrupt. A reload value of N-1 therefore gives an interrupt every N selected ticks; any other selected tick lowers the count by one.
- R6: With periodic mode clear, a selected tick at count zero wraps the count to all ones of the channel width and still sets the interrupt.
- R7: Clock select 1 makes the channel count on `tick_main`; clock select 0 makes it count on `tick_alt`. The tick that is not selected has no effect.
- R8: A disabled channel holds its count whatever ticks arrive.
- R9: A write of any data to a channel's clear port drops only that channel's interrupt. If an underflow happens in the same cycle, the interrupt stays set.
- R10: Channels 0 and 1 wrap to 0x0000FFFF and channel 2 wraps to 0xFFFFFFFF.
- R11: Bit 8 of the high word enables the wide counter. While enabled, it counts up by one on each `tick_fast`. While disabled, it is held at zero. It ignores the other ticks and drives no interrupt.
- R12: A low-word read captures counter bits 39:32 in the same cycle. A high-word read returns the enable at bit 8 and those captured bits at bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_main | input | 1 | Main tick enable for the down-channels |
| tick_alt | input | 1 | Slower alternative tick enable for the down-channels |
| tick_fast | input | 1 | Tick enable for the wide counter |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Pending interrupt per down-channel |

## Verification
The assertions check the following on every cycle:
- A disabled channel keeps its count.
- A running channel either steps down by one or handles underflow by setting its interrupt.
- A clear with no concurrent underflow drops the interrupt.
- The wide counter stays at zero while off and adds one per fast tick while on.
- An unmapped read returns zero.

Other behaviour needs the bench's scenarios:
- The exact interrupt period for a given reload value.
- The choice between reload and wrap.
- The per-channel widths.
- Which tick a channel follows.
- That a low-word read captures the upper bits that a later high-word read returns.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {CH_OFF, CH_RUN} ch_state_t;
    typedef enum logic {FR_OFF, FR_RUN} fr_state_t;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic en;
        logic per;
        logic clk;
    } chan_ctl_t;

    localparam int CTL_EN_BIT  = 7;
    localparam int CTL_PER_BIT = 6;
    localparam int CTL_CLK_BIT = 3;
    localparam int FR_EN_BIT   = 8;
endpackage

// File: rtl/tmr_down_chan.sv
module tmr_down_chan
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_main,
    input  logic          tick_alt,
    input  logic          load_we,
    input  logic [CW-1:0] load_data,
    input  logic          ctrl_we,
    input  chan_ctl_t     ctrl_data,
    input  logic          clr_we,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] load_o,
    output chan_ctl_t     ctl_o,
    output logic          irq_o
);
    ch_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, reload_q;
    logic          per_q, clk_sel_q, irq_q;
    logic          tk, step, under;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (ctrl_we && ctrl_data.en)  state_d = CH_RUN;
            CH_RUN: if (ctrl_we && !ctrl_data.en) state_d = CH_OFF;
        endcase
    end

    assign tk    = clk_sel_q ? tick_main : tick_alt;
    assign step  = (state_q == CH_RUN) && tk;
    assign under = step && (cnt_q == '0);

    // outputs / datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            reload_q  <= '0;
            per_q     <= 1'b0;
            clk_sel_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (ctrl_we) begin
                per_q     <= ctrl_data.per;
                clk_sel_q <= ctrl_data.clk;
            end
            if (load_we) reload_q <= load_data;
            if (step) begin
                if (under) cnt_q <= per_q ? reload_q : '1;
                else       cnt_q <= cnt_q - 1'b1;
            end else if (load_we && state_q == CH_OFF) begin
                cnt_q <= load_data;
            end
            if (under)       irq_q <= 1'b1;
            else if (clr_we) irq_q <= 1'b0;
        end
    end

    always_comb begin
        count_o           = '0;
        count_o[CW-1:0]   = cnt_q;
        load_o            = '0;
        load_o[CW-1:0]    = reload_q;
        ctl_o.en          = (state_q == CH_RUN);
        ctl_o.per         = per_q;
        ctl_o.clk         = clk_sel_q;
        irq_o             = irq_q;
    end

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF && !load_we) |=> $stable(cnt_q)); // R8
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
    AST_UNDER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        under |=> irq_q); // R5
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !under) |=> !irq_q); // R9
endmodule

// File: rtl/tmr_free_ctr.sv
module tmr_free_ctr
    import tmr_pkg::*;
#(
    parameter int FW = 40,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hi_we,
    input  logic          en_data,
    input  logic          lo_rd,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o
);
    localparam int HW = FW - DW;

    fr_state_t     state_q, state_d;
    logic [FW-1:0] cnt_q;
    logic [HW-1:0] hi_cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FR_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_OFF: if (hi_we && en_data)  state_d = FR_RUN;
            FR_RUN: if (hi_we && !en_data) state_d = FR_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            hi_cap_q <= '0;
        end else begin
            if (state_q == FR_OFF) cnt_q <= '0;
            else if (tick)         cnt_q <= cnt_q + 1'b1;
            if (lo_rd) hi_cap_q <= cnt_q[FW-1:DW];
        end
    end

    always_comb begin
        lo_o             = cnt_q[DW-1:0];
        hi_o             = '0;
        hi_o[HW-1:0]     = hi_cap_q;
        hi_o[FR_EN_BIT]  = (state_q == FR_RUN);
    end

    AST_FREE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_OFF) |=> (cnt_q == '0)); // R11
    AST_FREE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_RUN && tick) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R11
endmodule

// File: rtl/reload_timer_bank.sv
module reload_timer_bank
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FREE_W   = 40,
    parameter int NUM_CH   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_main,
    input  logic              tick_alt,
    input  logic              tick_fast,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [ADDR_W-1:0] FREE_LO_ADDR = ADDR_W'(8'h60);
    localparam logic [ADDR_W-1:0] FREE_HI_ADDR = ADDR_W'(8'h64);

    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        case (idx)
            0:       chan_base = ADDR_W'(8'h00);
            1:       chan_base = ADDR_W'(8'h20);
            default: chan_base = ADDR_W'(8'h80);
        endcase
    endfunction

    reg_sel_t          sel;
    logic [NUM_CH-1:0] hit;
    logic              lo_hit, hi_hit, any_hit;
    logic [DATA_W-1:0] ch_count [NUM_CH];
    logic [DATA_W-1:0] ch_load  [NUM_CH];
    chan_ctl_t         ch_ctl   [NUM_CH];
    logic [DATA_W-1:0] free_lo, free_hi, rd_mux;
    chan_ctl_t         wr_ctl;

    assign sel        = reg_sel_t'(bus_addr[3:2]);
    assign lo_hit     = (bus_addr == FREE_LO_ADDR);
    assign hi_hit     = (bus_addr == FREE_HI_ADDR);
    assign wr_ctl.en  = bus_wdata[CTL_EN_BIT];
    assign wr_ctl.per = bus_wdata[CTL_PER_BIT];
    assign wr_ctl.clk = bus_wdata[CTL_CLK_BIT];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        localparam int CW = (i == NUM_CH - 1) ? WIDE_W : NARROW_W;
        localparam logic [ADDR_W-1:0] BASE = chan_base(i);

        assign hit[i] = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) &&
                        (bus_addr[1:0] == 2'b00);

        tmr_down_chan #(.CW(CW), .DW(DATA_W)) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_main (tick_main),
            .tick_alt  (tick_alt),
            .load_we   (bus_wr && hit[i] && sel == REG_LOAD),
            .load_data (bus_wdata[CW-1:0]),
            .ctrl_we   (bus_wr && hit[i] && sel == REG_CTRL),
            .ctrl_data (wr_ctl),
            .clr_we    (bus_wr && hit[i] && sel == REG_CLEAR),
            .count_o   (ch_count[i]),
            .load_o    (ch_load[i]),
            .ctl_o     (ch_ctl[i]),
            .irq_o     (irq[i])
        );
    end

    tmr_free_ctr #(.FW(FREE_W), .DW(DATA_W)) free_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_fast),
        .hi_we   (bus_wr && hi_hit),
        .en_data (bus_wdata[FR_EN_BIT]),
        .lo_rd   (bus_rd && lo_hit),
        .lo_o    (free_lo),
        .hi_o    (free_hi)
    );

    assign any_hit = (|hit) || lo_hit || hi_hit;

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) begin
                unique case (sel)
                    REG_LOAD:  rd_mux = ch_load[i];
                    REG_COUNT: rd_mux = ch_count[i];
                    REG_CTRL: begin
                        rd_mux[CTL_EN_BIT]  = ch_ctl[i].en;
                        rd_mux[CTL_PER_BIT] = ch_ctl[i].per;
                        rd_mux[CTL_CLK_BIT] = ch_ctl[i].clk;
                    end
                    REG_CLEAR: rd_mux = '0;
                endcase
            end
        end
        if (lo_hit) rd_mux = free_lo;
        if (hi_hit) rd_mux = free_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !any_hit) |=> (bus_rdata == '0)); // R2
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2
endmodule

// File: tb/reload_timer_bank_tb.sv
module reload_timer_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_main = 1'b0, tick_alt = 1'b0, tick_fast = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    always #2 clk = ~clk;

    reload_timer_bank dut_i (
        .clk(clk), .rst_n(rst_n), .tick_main(tick_main), .tick_alt(tick_alt),
        .tick_fast(tick_fast), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    typedef struct {
        logic [31:0] v;
        string       r;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    logic rd_d = 1'b0;
    bit done = 1'b0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: read data registered at the edge after the strobe
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(bus_rdata, e.v, e.r);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tm = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_main = tm;
        @(negedge clk);
        bus_wr = 1'b0; tick_main = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        exp_t x;
        x.v = e; x.r = req;
        exp_q.push_back(x);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tk_main(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_main = 1'b1;
            @(negedge clk); tick_main = 1'b0;
        end
    endtask

    task automatic tk_alt(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_alt = 1'b1;
            @(negedge clk); tick_alt = 1'b0;
        end
    endtask

    task automatic tk_fast(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_fast = 1'b1;
            @(negedge clk); tick_fast = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk({29'b0, irq}, 32'h0, "R1 irq");
        rd(8'h04, 32'h0, "R1 t0 count");
        rd(8'h08, 32'h0, "R1 t0 ctrl");
        rd(8'h24, 32'h0, "R1 t1 count");
        rd(8'h84, 32'h0, "R1 t2 count");
        rd(8'h60, 32'h0, "R1 free lo");
        rd(8'h64, 32'h0, "R1 free hi");

        // channel 0: periodic, main tick, reload 4
        wr(8'h08, 32'h48);
        wr(8'h00, 32'h4);
        rd(8'h04, 32'h4, "R4 load copied while off");
        rd(8'h00, 32'h4, "R2 reload readback");
        rd(8'h08, 32'h48, "R3 ctrl readback");
        wr(8'h08, 32'hC8);
        rd(8'h08, 32'hC8, "R3 enable bit");
        tk_main(4);
        rd(8'h04, 32'h0, "R5 counted down");
        chk({29'b0, irq}, 32'h0, "R5 no irq before period");
        tk_main(1);
        chk({29'b0, irq}, 32'h1, "R5 irq after N ticks");
        rd(8'h04, 32'h4, "R5 reloaded");
        wr(8'h00, 32'h7);
        rd(8'h04, 32'h4, "R4 load while running keeps count");
        wr(8'h0C, 32'h1234);
        chk({29'b0, irq}, 32'h0, "R9 clear any value");
        tk_main(5);
        chk({29'b0, irq}, 32'h1, "R5 second period");
        rd(8'h04, 32'h7, "R4 new reload used");
        wr(8'h0C, 32'h0);
        tk_main(7);
        rd(8'h04, 32'h0, "R5 at zero");
        wr(8'h0C, 32'h0, 1'b1);
        chk({29'b0, irq}, 32'h1, "R9 underflow wins over clear");
        rd(8'h04, 32'h7, "R5 reload on underflow");
        wr(8'h0C, 32'h0);
        chk({29'b0, irq}, 32'h0, "R9 cleared");
        wr(8'h08, 32'h48);
        tk_main(3);
        rd(8'h04, 32'h7, "R8 disabled holds");
        wr(8'h08, 32'h37);
        rd(8'h08, 32'h0, "R3 other bits read zero");

        // channel 1: periodic, alternative tick
        wr(8'h28, 32'h40);
        wr(8'h20, 32'h3);
        wr(8'h28, 32'hC0);
        tk_main(3);
        rd(8'h24, 32'h3, "R7 unselected tick ignored");
        tk_alt(2);
        rd(8'h24, 32'h1, "R7 alt tick counts");
        tk_alt(2);
        chk({29'b0, irq}, 32'h2, "R5 ch1 irq");
        rd(8'h24, 32'h3, "R5 ch1 reloaded");
        wr(8'h0C, 32'h0);
        chk({29'b0, irq}, 32'h2, "R9 other clear leaves ch1");
        wr(8'h2C, 32'h0);
        chk({29'b0, irq}, 32'h0, "R9 ch1 cleared");
        wr(8'h28, 32'h40);
        tk_alt(3);
        rd(8'h24, 32'h3, "R8 ch1 disabled holds");

        // channel 2: one-shot wrap, 32 bit
        wr(8'h88, 32'h08);
        wr(8'h80, 32'h1);
        wr(8'h88, 32'h88);
        rd(8'h88, 32'h88, "R3 ch2 ctrl");
        tk_main(1);
        rd(8'h84, 32'h0, "R5 ch2 step");
        tk_main(1);
        rd(8'h84, 32'hFFFF_FFFF, "R6 R10 wide wrap");
        chk({29'b0, irq}, 32'h4, "R6 wrap raises irq");
        tk_main(1);
        rd(8'h84, 32'hFFFF_FFFE, "R6 continues down");

        // channel 1 narrow wrap
        wr(8'h28, 32'h08);
        wr(8'h20, 32'h0);
        wr(8'h28, 32'h88);
        tk_main(1);
        rd(8'h24, 32'h0000_FFFF, "R10 narrow wrap");
        chk({29'b0, irq}, 32'h6, "R6 ch1 wrap irq");
        rd(8'h04, 32'h7, "R8 ch0 still holds");

        // wide counter
        wr(8'h64, 32'h100);
        tk_fast(10);
        rd(8'h60, 32'd10, "R11 counts fast ticks");
        rd(8'h64, 32'h100, "R12 high word enable and captured bits");
        tk_main(3);
        tk_alt(2);
        rd(8'h60, 32'd10, "R11 other ticks ignored");
        chk({29'b0, irq}, 32'h6, "R11 no irq from wide counter");
        wr(8'h64, 32'h0);
        repeat (2) @(negedge clk);
        rd(8'h60, 32'h0, "R11 disabled held zero");
        rd(8'h64, 32'h0, "R11 R12 disabled high word");

        // unmapped
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, 32'h0, "R2 unmapped read");
        rd(8'h70, 32'h0, "R2 unmapped read 0x70");
        rd(8'h05, 32'h0, "R2 misaligned read");
        chk({29'b0, irq}, 32'h6, "R2 unmapped write no effect");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule